// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block receives asynchronous serial characters on a single input line. A falling edge starts a frame, and the low level is confirmed at the middle of the start bit. Data bits then arrive least significant first. Each bit is sampled once, at its centre, using a sample tick that runs at a fixed multiple of the bit rate. Frames carry either 8 or 9 data bits and end with one stop bit.

Each completed character is stored in a two-entry first-in first-out buffer together with its framing status. The consumer reads characters with a one-cycle read strobe. An interrupt output stays high while any character is waiting.

When both entries are full and another character completes, that character is lost. A sticky overrun flag is then set and reception stops. Reception resumes only after the receiver has been disabled and enabled again.

In 9-bit mode an optional address filter keeps only frames whose ninth bit is 1. This lets a node on a shared line ignore traffic meant for other nodes.

Top module: `rxb_top`

## Requirements
- R1: With `nine_bit_i`=0, a frame (start 0, eight data bits with the least significant bit first, stop 1) appears as `data_o` at the head of the buffer, and `bit9_o` reads 0.
- R2: The buffer holds two characters and presents the oldest one first. A cycle with `rd_i`=1 removes the head entry when the buffer is not empty.
- R3: `frame_err_o` is 1 for a character whose stop bit was sampled low and 0 otherwise. The flag stays attached to its own character inside the buffer.
- R4: With `nine_bit_i`=1, nine data bits are received. The ninth bit received appears on `bit9_o` and the first eight appear on `data_o`.
- R5: A character that completes while both entries are full is dropped, `overrun_o` is set, and the two stored entries are unchanged.
- R6: While `overrun_o`=1 no further character is stored. `overrun_o` stays set until a cycle with `en_i`=0 clears it.
- R7: With `nine_bit_i`=1 and `addr_det_i`=1, a frame whose ninth bit is 0 is discarded and a frame whose ninth bit is 1 is stored.
- R8: `avail_o` is 1 exactly when the buffer holds at least one character.
- R9: A low pulse on the line that has ended before the middle of the start bit produces no character.
- R10: While `en_i`=0, frames on the line produce no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial input line; idles high |
| tick_i | input | 1 | Sample tick, OVS ticks per bit |
| en_i | input | 1 | Receiver enable; a low level clears overrun |
| nine_bit_i | input | 1 | 1 selects 9 data bits |
| addr_det_i | input | 1 | In 9-bit mode, keep only frames whose ninth bit is 1 |
| rd_i | input | 1 | Read strobe; removes the head character |
| data_o | output | 8 | Head character data |
| bit9_o | output | 1 | Head character ninth bit |
| frame_err_o | output | 1 | Head character framing error |
| overrun_o | output | 1 | Sticky overrun flag |
| avail_o | output | 1 | Buffer not empty |

## Verification
A character is stored in the cycle after the stop bit is sampled, which is half a bit time after the stop bit begins plus the two input synchronizer stages. The bench therefore waits until the whole stop bit and half a bit of idle line have passed before it compares the head entry, `avail_o` or `overrun_o`. A read strobe takes effect at the next clock edge, so each check after a read samples on the following falling edge. Every stimulus is driven on a falling edge, away from the register updates.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef struct packed {
    logic       ferr;
    logic       b9;
    logic [7:0] data;
  } rx_char_t;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;
endpackage

// File: rtl/rxb_frame.sv
module rxb_frame
  import rxb_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     tick_i,
  input  logic     rx_i,
  input  logic     nine_i,
  output logic     done_o,
  output rx_char_t char_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] CNT_HALF = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(OVS - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    bit_q;
  logic [8:0]    sh_q;
  logic [3:0]    last_bit;

  assign last_bit = nine_i ? 4'd8 : 4'd7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      done_o  <= 1'b0;
      char_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!run_i) begin
        state_q <= S_IDLE;
      end else if (tick_i) begin
        unique case (state_q)
          S_IDLE: if (!rx_i) begin
            state_q <= S_START;
            cnt_q   <= '0;
          end
          S_START: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_HALF) begin
              // confirm start at its centre, else treat as glitch
              state_q <= rx_i ? S_IDLE : S_DATA;
              cnt_q   <= '0;
              bit_q   <= '0;
            end
          end
          S_DATA: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_FULL) begin
              cnt_q <= '0;
              sh_q  <= {rx_i, sh_q[8:1]};
              bit_q <= bit_q + 1'b1;
              if (bit_q == last_bit) state_q <= S_STOP;
            end
          end
          S_STOP: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_FULL) begin
              state_q     <= S_IDLE;
              done_o      <= 1'b1;
              char_o.ferr <= ~rx_i;
              char_o.b9   <= nine_i & sh_q[8];
              char_o.data <= nine_i ? sh_q[7:0] : sh_q[8:1];
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo
  import rxb_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  rx_char_t         din_i,
  output rx_char_t         dout_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  rx_char_t      mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (count_o == CNT_W'(DEPTH));
  assign empty_o = (count_o == '0);
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= din_i;
        wr_q        <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      count_o <= count_o + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end
endmodule

// File: rtl/rxb_top.sv
module rxb_top
  import rxb_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       nine_bit_i,
  input  logic       addr_det_i,
  input  logic       rd_i,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       frame_err_o,
  output logic       overrun_o,
  output logic       avail_o
);
  logic [1:0]       rx_sync_q;
  logic             ovr_q, done, accept, push, pop, full, empty;
  rx_char_t         frm_char, head;
  logic [CNT_W-1:0] fifo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_sync_q <= 2'b11;
    else         rx_sync_q <= {rx_sync_q[0], rx_i};
  end

  rxb_frame #(.OVS(OVS)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i & ~ovr_q),
    .tick_i (tick_i),
    .rx_i   (rx_sync_q[1]),
    .nine_i (nine_bit_i),
    .done_o (done),
    .char_o (frm_char)
  );

  // address filter: in 9-bit address mode drop frames with ninth bit clear
  assign accept = done & ~(nine_bit_i & addr_det_i & ~frm_char.b9);
  assign push   = accept & ~full;
  assign pop    = rd_i & ~empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (!en_i)     ovr_q <= 1'b0;
    else if (accept && full) ovr_q <= 1'b1;
  end

  rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (frm_char),
    .dout_o  (head),
    .count_o (fifo_cnt),
    .full_o  (full),
    .empty_o (empty)
  );

  assign data_o      = head.data;
  assign bit9_o      = head.b9;
  assign frame_err_o = head.ferr;
  assign overrun_o   = ovr_q;
  assign avail_o     = ~empty;
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             nine_i,
  input logic             addr_det_i,
  input logic             rd_i,
  input logic             avail_o,
  input logic             overrun_o,
  input logic [CNT_W-1:0] count_i,
  input logic             push_i,
  input logic             push_b9_i
);
  p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));

  p_read_pops_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && count_i == CNT_W'(1) && !push_i) |=> !avail_o);

  p_no_push_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> count_i < CNT_W'(DEPTH));

  p_overrun_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(count_i) == CNT_W'(DEPTH));

  p_overrun_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && en_i) |=> overrun_o);

  p_overrun_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !overrun_o);

  p_addr_filter_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && nine_i && addr_det_i) |-> push_b9_i);
endmodule

bind rxb_top rxb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .nine_i     (nine_bit_i),
  .addr_det_i (addr_det_i),
  .rd_i       (rd_i),
  .avail_o    (avail_o),
  .overrun_o  (overrun_o),
  .count_i    (fifo_cnt),
  .push_i     (push),
  .push_b9_i  (frm_char.b9)
);

// File: tb/rxb_top_bench.sv
module rxb_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OVS        = 16;
  localparam int BIT_CLKS   = OVS * TICK_DIV;

  logic clk = 1'b0, rst_ni = 1'b0, rx = 1'b1, tick = 1'b0;
  logic en = 1'b0, nine = 1'b0, adet = 1'b0, rd = 1'b0;
  logic [7:0] data;
  logic bit9, ferr, ovr, avail;
  int checks = 0, errors = 0, tdiv = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_DIV - 1);
  end

  rxb_top #(.OVS(OVS), .DEPTH(2)) u_rxb_top (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx), .tick_i(tick), .en_i(en),
    .nine_bit_i(nine), .addr_det_i(adet), .rd_i(rd), .data_o(data),
    .bit9_o(bit9), .frame_err_o(ferr), .overrun_o(ovr), .avail_o(avail)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input bit nb, input logic stop);
    rx = 1'b0; hold(BIT_CLKS);
    for (int i = 0; i < (nb ? 9 : 8); i++) begin
      rx = d[i]; hold(BIT_CLKS);
    end
    rx = stop; hold(BIT_CLKS);
    rx = 1'b1; hold(BIT_CLKS / 2);
  endtask

  task automatic read();
    rd = 1'b1; hold(1); rd = 1'b0;
  endtask

  task automatic drain();
    while (avail) read();
  endtask

  task automatic t_reset();
    check("R8 reset avail", avail, 0);
    check("R6 reset overrun", ovr, 0);
  endtask

  task automatic t_basic();
    send(9'h0A5, 0, 1);
    check("R8 avail", avail, 1);
    check("R1 data", data, 8'hA5);
    check("R1 bit9", bit9, 0);
    check("R3 no ferr", ferr, 0);
    read();
    check("R8 empty after read", avail, 0);
  endtask

  task automatic t_order();
    send(9'h03C, 0, 0);
    send(9'h0C3, 0, 1);
    check("R2 head first", data, 8'h3C);
    check("R3 ferr first", ferr, 1);
    read();
    check("R2 head second", data, 8'hC3);
    check("R3 ferr second", ferr, 0);
    read();
    check("R2 drained", avail, 0);
  endtask

  task automatic t_overrun();
    send(9'h011, 0, 1);
    send(9'h022, 0, 1);
    check("R5 no overrun yet", ovr, 0);
    send(9'h033, 0, 1);
    check("R5 overrun set", ovr, 1);
    send(9'h044, 0, 1);
    check("R6 overrun held", ovr, 1);
    check("R5 head kept", data, 8'h11);
    read();
    check("R5 second kept", data, 8'h22);
    read();
    check("R6 blocked frame lost", avail, 0);
    send(9'h066, 0, 1);
    check("R6 still blocked", avail, 0);
    en = 1'b0; hold(2); en = 1'b1; hold(2);
    check("R6 cleared by disable", ovr, 0);
    send(9'h055, 0, 1);
    check("R6 reception resumes", data, 8'h55);
    drain();
  endtask

  task automatic t_nine();
    nine = 1'b1;
    send(9'h15A, 1, 1);
    check("R4 data", data, 8'h5A);
    check("R4 bit9 one", bit9, 1);
    read();
    send(9'h0E1, 1, 1);
    check("R4 bit9 zero", bit9, 0);
    check("R4 data2", data, 8'hE1);
    read();
    nine = 1'b0;
  endtask

  task automatic t_addr();
    nine = 1'b1; adet = 1'b1;
    send(9'h077, 1, 1);
    check("R7 data frame dropped", avail, 0);
    send(9'h1A2, 1, 1);
    check("R7 address kept", avail, 1);
    check("R7 address data", data, 8'hA2);
    drain();
    nine = 1'b0; adet = 1'b0;
  endtask

  task automatic t_glitch();
    rx = 1'b0; hold(3 * TICK_DIV); rx = 1'b1; hold(2 * BIT_CLKS);
    check("R9 glitch rejected", avail, 0);
    send(9'h096, 0, 1);
    check("R9 frame after glitch", data, 8'h96);
    drain();
  endtask

  task automatic t_disabled();
    en = 1'b0;
    send(9'h0F0, 0, 1);
    check("R10 disabled ignored", avail, 0);
    en = 1'b1; hold(2);
  endtask

  initial begin
    hold(4); rst_ni = 1'b1; hold(2);
    t_reset();
    en = 1'b1; hold(2);
    t_basic();
    t_order();
    t_overrun();
    t_nine();
    t_addr();
    t_glitch();
    t_disabled();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule